// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block keeps an asynchronous 16-bit-wide DRAM with 1024 refresh rows alive. After reset it holds every strobe inactive for a power-up pause. It then drives a fixed number of initial refresh cycles on its own, and only after that does it raise `init_done`, which the access sequencer uses to gate normal accesses. From then on an interval timer adds one owed refresh per period to a saturating backlog. The interval defaults to the 16 ms window divided by 1024 rows.

Every refresh is a CAS-before-RAS cycle. Both column strobes fall first, then the row strobe falls, and the column strobes rise again while the row strobe is still low. Write enable stays high throughout. The internal row counter of the memory supplies the row, so no address is driven and the data bus is never enabled. Pins are shared with the access sequencer through a request/grant handshake. The scheduler raises `rfsh_req`, and it starts a cycle only in a clock cycle where `rfsh_gnt` is high and no cycle of its own is running. While it owns the pins it holds `rfsh_busy`.

A host sleep request puts the memory into self-refresh. The block uses the same strobe ordering and keeps the row strobe low for at least the minimum self-refresh time. On leaving, it keeps all strobes high for an exit recovery time. Owed refreshes are served before sleep is entered. All timings are clock-cycle parameters whose defaults come from nanosecond limits at a 4 ns clock.

Top module: `dram_rfsh_sched`

## Requirements
- R1: For PAUSE_CYC cycles after reset, `ras_n`, `lcas_n`, `ucas_n` and `we_n` stay high, `init_done` stays low and `rfsh_req` stays low.
- R2: After the pause, exactly INIT_CNT refresh cycles run without any grant. `init_done` rises only after the last of them, and `rfsh_req` is never high while `init_done` is low.
- R3: In each refresh cycle both column strobes are low together for exactly LEAD_CYC cycles before `ras_n` falls. They stay low for exactly HOLD_CYC cycles after it falls, and they do not fall again while `ras_n` is low.
- R4: `we_n` is high in every cycle, including every cycle where any strobe is low.
- R5: A refresh cycle holds `ras_n` low for exactly RAS_LOW_CYC cycles. `ras_n` is high for at least PRE_CYC cycles before every falling edge.
- R6: Once `init_done` is high, one refresh is owed every INTERVAL_CYC cycles. With `rfsh_gnt` held high and no sleep, successive `ras_n` falling edges are exactly INTERVAL_CYC cycles apart.
- R7: With a refresh owed and `rfsh_gnt` low, `rfsh_req` is high, `rfsh_busy` is low and no strobe moves. A cycle starts only when `rfsh_gnt` is high, and `rfsh_busy` is high whenever a strobe is low.
- R8: The backlog of owed refreshes saturates at BACKLOG_MAX. Intervals that expire while it is full are dropped, so granting after a long stall serves exactly BACKLOG_MAX cycles.
- R9: `sleep_req` with no refresh owed and the grant high starts a self-refresh. `sleep_ack` is high while it lasts, with `ras_n` and both column strobes low. `ras_n` stays low at least SELF_MIN_CYC cycles even if `sleep_req` drops earlier. After exit, `ras_n` stays high at least EXIT_CYC cycles before it falls again.
- R10: When `sleep_req` arrives while a refresh is owed, the owed refresh cycle runs first and the self-refresh follows.
- R11: Once `init_done` is high it never falls until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rfsh_gnt | input | 1 | Access sequencer hands over the strobe pins |
| sleep_req | input | 1 | Host asks for self-refresh while high |
| rfsh_req | output | 1 | A refresh is owed or sleep is pending and no cycle is running |
| rfsh_busy | output | 1 | Scheduler currently owns the strobe pins |
| init_done | output | 1 | Power-up pause and initial refresh cycles complete |
| sleep_ack | output | 1 | Memory is held in self-refresh |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| we_n | output | 1 | Write enable, active low, high during refresh |

## Verification
The bench builds the block with a 40-cycle pause, eight initial cycles, a 60-cycle interval, a 2/3/6/4-cycle lead, hold, row-low and precharge, a 20-cycle self-refresh minimum, a 5-cycle exit recovery and a backlog limit of 3. These values put the whole power-up sequence, several refresh intervals, saturation of the backlog after a stalled grant, and two self-refresh entries within a few hundred cycles. The short self-refresh minimum means the bench can drop the sleep request early and still see the row strobe held for the full minimum.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [1:0] {PH_PAUSE, PH_INIT, PH_RUN} phase_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_LEAD, SQ_ROW, SQ_PRE, SQ_SELF, SQ_EXIT
  } seq_e;

  // smallest cycle count covering a time in picoseconds
  function automatic int cyc_of_ps(longint ps, longint clk_ps);
    return int'((ps + clk_ps - 1) / clk_ps);
  endfunction

  // cycles between refreshes so that all rows fit inside the window
  function automatic int interval_cyc(longint window_ps, longint rows, longint clk_ps);
    return int'(window_ps / rows / clk_ps);
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfsh_tick_gen.sv
module rfsh_tick_gen #(
  parameter int PERIOD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (PERIOD < 2) ? 1 : $clog2(PERIOD);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en)        cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == LAST);
endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
  parameter int MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic nz
);
  localparam int CW = $clog2(MAX + 1);
  localparam logic [CW-1:0] TOP = CW'(MAX);

  logic [CW-1:0] cnt;
  logic          up, down;

  assign up   = inc && (cnt != TOP);
  assign down = dec && (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (up && !down)  cnt <= cnt + 1'b1;
    else if (down && !up)  cnt <= cnt - 1'b1;
  end

  assign nz = (cnt != '0);
endmodule

// File: rtl/rfsh_strobe_seq.sv
module rfsh_strobe_seq
  import dram_rfsh_pkg::*;
#(
  parameter int LEAD     = 2,
  parameter int HOLD     = 3,
  parameter int RASL     = 15,
  parameter int PRE      = 10,
  parameter int SELF_MIN = 25000,
  parameter int EXIT     = 28
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic self_sel,
  input  logic sleep_req,
  output logic idle,
  output logic cbr_done,
  output logic in_self,
  output logic ras_n,
  output logic cas_n
);
  localparam int CMAX = max2(max2(max2(LEAD, RASL), max2(PRE, EXIT)), SELF_MIN);
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] LEAD_LAST = CW'(LEAD - 1);
  localparam logic [CW-1:0] ROW_LAST  = CW'(RASL - 1);
  localparam logic [CW-1:0] PRE_LAST  = CW'(PRE - 1);
  localparam logic [CW-1:0] SELF_LAST = CW'(SELF_MIN - 1);
  localparam logic [CW-1:0] EXIT_LAST = CW'(EXIT - 1);
  localparam logic [CW-1:0] HOLD_C    = CW'(HOLD);

  seq_e          state;
  logic [CW-1:0] cnt;
  logic          self_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      cnt    <= '0;
      self_q <= 1'b0;
    end else begin
      unique case (state)
        SQ_IDLE: if (start) begin
          state  <= SQ_LEAD;
          cnt    <= '0;
          self_q <= self_sel;
        end
        SQ_LEAD: if (cnt == LEAD_LAST) begin
          state <= self_q ? SQ_SELF : SQ_ROW;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        SQ_ROW: if (cnt == ROW_LAST) begin
          state <= SQ_PRE;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        SQ_PRE: if (cnt == PRE_LAST) begin
          state <= SQ_IDLE;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        SQ_SELF: if (cnt >= SELF_LAST && !sleep_req) begin
          state <= SQ_EXIT;
          cnt   <= '0;
        end else if (cnt < SELF_LAST) cnt <= cnt + 1'b1;
        SQ_EXIT: if (cnt == EXIT_LAST) begin
          state <= SQ_IDLE;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign idle     = (state == SQ_IDLE);
  assign cbr_done = (state == SQ_PRE) && (cnt == PRE_LAST);
  assign in_self  = (state == SQ_SELF);
  assign ras_n    = !((state == SQ_ROW) || (state == SQ_SELF));
  assign cas_n    = !((state == SQ_LEAD) || (state == SQ_SELF) ||
                      ((state == SQ_ROW) && (cnt < HOLD_C)));
endmodule

// File: rtl/dram_rfsh_sched.sv
module dram_rfsh_sched
  import dram_rfsh_pkg::*;
#(
  parameter int CLK_PS       = 4000,
  parameter int PAUSE_CYC    = cyc_of_ps(64'd100_000_000, CLK_PS),
  parameter int INIT_CNT     = 8,
  parameter int INTERVAL_CYC = interval_cyc(64'd16_000_000_000, 1024, CLK_PS),
  parameter int LEAD_CYC     = cyc_of_ps(5_000, CLK_PS),
  parameter int HOLD_CYC     = cyc_of_ps(10_000, CLK_PS),
  parameter int RAS_LOW_CYC  = cyc_of_ps(60_000, CLK_PS),
  parameter int PRE_CYC      = cyc_of_ps(40_000, CLK_PS),
  parameter int SELF_MIN_CYC = cyc_of_ps(64'd100_000_000, CLK_PS),
  parameter int EXIT_CYC     = cyc_of_ps(110_000, CLK_PS),
  parameter int BACKLOG_MAX  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rfsh_gnt,
  input  logic sleep_req,
  output logic rfsh_req,
  output logic rfsh_busy,
  output logic init_done,
  output logic sleep_ack,
  output logic ras_n,
  output logic lcas_n,
  output logic ucas_n,
  output logic we_n
);
  localparam int IW = $clog2(INIT_CNT + 1);

  phase_e        phase;
  logic [IW-1:0] init_left;

  // named internal events, also used by the checker
  logic pause_tick, ival_tick;
  logic seq_idle, seq_start, seq_self, cbr_done, in_self, cas_n;
  logic owed, run;

  assign run = (phase == PH_RUN);

  rfsh_tick_gen #(.PERIOD(PAUSE_CYC)) u_pause (
    .clk(clk), .rst_n(rst_n), .en(phase == PH_PAUSE), .tick(pause_tick)
  );

  rfsh_tick_gen #(.PERIOD(INTERVAL_CYC)) u_ival (
    .clk(clk), .rst_n(rst_n), .en(run), .tick(ival_tick)
  );

  rfsh_backlog #(.MAX(BACKLOG_MAX)) u_backlog (
    .clk(clk), .rst_n(rst_n), .inc(ival_tick), .dec(run && cbr_done), .nz(owed)
  );

  // owed refresh first, sleep only when nothing is owed
  assign seq_self  = run && seq_idle && rfsh_gnt && !owed && sleep_req;
  assign seq_start = seq_idle &&
                     (((phase == PH_INIT) && (init_left != '0)) ||
                      (run && rfsh_gnt && (owed || sleep_req)));

  rfsh_strobe_seq #(
    .LEAD(LEAD_CYC), .HOLD(HOLD_CYC), .RASL(RAS_LOW_CYC), .PRE(PRE_CYC),
    .SELF_MIN(SELF_MIN_CYC), .EXIT(EXIT_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .self_sel(seq_self),
    .sleep_req(sleep_req), .idle(seq_idle), .cbr_done(cbr_done),
    .in_self(in_self), .ras_n(ras_n), .cas_n(cas_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_PAUSE;
      init_left <= IW'(INIT_CNT);
    end else begin
      unique case (phase)
        PH_PAUSE: if (pause_tick) phase <= PH_INIT;
        PH_INIT: begin
          if (cbr_done && init_left != '0) init_left <= init_left - 1'b1;
          if (init_left == '0 && seq_idle) phase <= PH_RUN;
        end
        default: phase <= PH_RUN;
      endcase
    end
  end

  assign init_done = run;
  assign rfsh_req  = run && seq_idle && (owed || sleep_req);
  assign rfsh_busy = !seq_idle;
  assign sleep_ack = in_self;
  assign lcas_n    = cas_n;
  assign ucas_n    = cas_n;
  assign we_n      = 1'b1;
endmodule

// File: rtl/dram_rfsh_chk.sv
module dram_rfsh_chk #(
  parameter int RASL = 15,
  parameter int PRE  = 10
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic lcas_n,
  input logic ucas_n,
  input logic we_n,
  input logic init_done,
  input logic rfsh_req,
  input logic rfsh_busy,
  input logic sleep_ack,
  input logic rfsh_gnt,
  input logic seq_start
);
  logic [31:0] low_cnt, hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      hi_cnt  <= 32'hFFFF_FFFF;
    end else begin
      low_cnt <= ras_n ? '0 : ((low_cnt == 32'hFFFF_FFFF) ? low_cnt : low_cnt + 1);
      hi_cnt  <= !ras_n ? '0 : ((hi_cnt == 32'hFFFF_FFFF) ? hi_cnt : hi_cnt + 1);
    end
  end

  a_r3_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!lcas_n && !ucas_n && $past(!lcas_n && !ucas_n)));

  a_r3_no_cas_fall_in_row: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lcas_n) || $fell(ucas_n)) |-> ras_n);

  a_r4_we_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !lcas_n || !ucas_n) |-> we_n);

  a_r5_ras_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (low_cnt >= 32'(RASL)));

  a_r5_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= 32'(PRE)));

  a_r2_no_req_before_init: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !rfsh_req);

  a_r7_start_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_start && init_done) |-> rfsh_gnt);

  a_r7_busy_covers_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !lcas_n || !ucas_n) |-> rfsh_busy);

  a_r9_self_strobes_low: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_ack |-> (!ras_n && !lcas_n && !ucas_n));

  a_r11_init_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(init_done) |-> init_done);
endmodule

bind dram_rfsh_sched dram_rfsh_chk #(.RASL(RAS_LOW_CYC), .PRE(PRE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
  .we_n(we_n), .init_done(init_done), .rfsh_req(rfsh_req), .rfsh_busy(rfsh_busy),
  .sleep_ack(sleep_ack), .rfsh_gnt(rfsh_gnt), .seq_start(seq_start)
);

// File: tb/tb_dram_rfsh_sched.sv
module tb_dram_rfsh_sched;
  localparam int PAUSE = 40, INITN = 8, IVAL = 60, LEAD = 2, HOLD = 3;
  localparam int RASL = 6, PRE = 4, SMIN = 20, EXITC = 5, BMAX = 3;

  typedef enum {K_CBR, K_SELF} kind_e;

  logic clk = 0, rst_n = 0, rfsh_gnt = 0, sleep_req = 0;
  logic rfsh_req, rfsh_busy, init_done, sleep_ack, ras_n, lcas_n, ucas_n, we_n;

  int total = 0, bad = 0;
  bit finished = 0;
  kind_e exp_q[$];

  always #2 clk = ~clk;

  dram_rfsh_sched #(
    .PAUSE_CYC(PAUSE), .INIT_CNT(INITN), .INTERVAL_CYC(IVAL), .LEAD_CYC(LEAD),
    .HOLD_CYC(HOLD), .RAS_LOW_CYC(RASL), .PRE_CYC(PRE), .SELF_MIN_CYC(SMIN),
    .EXIT_CYC(EXITC), .BACKLOG_MAX(BMAX)
  ) dut (
    .clk(clk), .rst_n(rst_n), .rfsh_gnt(rfsh_gnt), .sleep_req(sleep_req),
    .rfsh_req(rfsh_req), .rfsh_busy(rfsh_busy), .init_done(init_done),
    .sleep_ack(sleep_ack), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n), .we_n(we_n)
  );

  task automatic chk(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  // ---------------- monitor / scoreboard ----------------
  int cyc = 0, fall_cnt = 0, cbr_cnt = 0, fall_time = 0;
  int lead = 0, lead_at_fall = 0, hold = 0, low = 0, gap = 1000;
  bit prev_ras = 1, cas_ended = 0, after_self = 0, we_low_seen = 0, split_seen = 0;
  bit req_early = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit cas_lo = !lcas_n && !ucas_n;
      cyc++;
      if (!we_n) we_low_seen = 1;
      if (lcas_n != ucas_n) split_seen = 1;
      if (!init_done && rfsh_req) req_early = 1;
      if (ras_n && prev_ras) begin
        gap++;
        lead = cas_lo ? lead + 1 : 0;
      end else if (!ras_n && prev_ras) begin
        chk(gap >= PRE, "R5", "precharge before RAS fall", gap, PRE);
        if (after_self) chk(gap >= EXITC, "R9", "high time after self exit", gap, EXITC);
        fall_cnt++;
        fall_time = cyc;
        lead_at_fall = lead;
        low = 1;
        hold = cas_lo ? 1 : 0;
        cas_ended = !cas_lo;
      end else if (!ras_n && !prev_ras) begin
        low++;
        if (cas_lo && !cas_ended) hold++;
        else cas_ended = 1;
      end else begin
        automatic kind_e k = (low > RASL) ? K_SELF : K_CBR;
        gap = 1;
        lead = cas_lo ? 1 : 0;
        if (exp_q.size() > 0) begin
          automatic kind_e e = exp_q.pop_front();
          chk(k == e, "R10", "cycle kind in order", int'(k), int'(e));
        end else begin
          chk(k == K_CBR, "R9", "unrequested self-refresh", int'(k), int'(K_CBR));
        end
        chk(lead_at_fall == LEAD, "R3", "CAS lead before RAS", lead_at_fall, LEAD);
        chk(!we_low_seen, "R4", "WE high during cycle", int'(we_low_seen), 0);
        chk(!split_seen, "R3", "both CAS together", int'(split_seen), 0);
        if (k == K_CBR) begin
          chk(hold == HOLD, "R3", "CAS hold after RAS fall", hold, HOLD);
          chk(low == RASL, "R5", "RAS low width", low, RASL);
          cbr_cnt++;
          after_self = 0;
        end else begin
          chk(low >= SMIN, "R9", "self-refresh RAS low", low, SMIN);
          chk(hold == low, "R9", "CAS low through self-refresh", hold, low);
          after_self = 1;
        end
      end
      prev_ras = ras_n;
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(0, "WDOG", "run did not finish", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- driver ----------------
  initial begin
    int c0, f0, t1, i;
    bit pins_moved;
    for (int k = 0; k < INITN; k++) exp_q.push_back(K_CBR);
    repeat (3) step();
    chk(ras_n && lcas_n && ucas_n && we_n && !init_done && !rfsh_req && !rfsh_busy,
        "R1", "reset outputs", {ras_n, lcas_n, ucas_n, we_n, init_done}, 5'b11110);
    rst_n = 1;

    // R1: quiet pause
    pins_moved = 0;
    for (int k = 0; k < PAUSE - 1; k++) begin
      step();
      if (!ras_n || !lcas_n || !ucas_n || init_done || rfsh_req) pins_moved = 1;
    end
    chk(!pins_moved, "R1", "pins quiet during pause", int'(pins_moved), 0);

    // R2: initial cycles then init_done
    for (i = 0; i < 2000 && !init_done; i++) step();
    chk(init_done, "R2", "init_done rose", int'(init_done), 1);
    chk(cbr_cnt == INITN, "R2", "initial refresh count", cbr_cnt, INITN);
    chk(fall_cnt == INITN, "R2", "RAS falls before init_done", fall_cnt, INITN);
    chk(!req_early, "R2", "no request before init_done", int'(req_early), 0);

    // R7: owed refresh waits for grant
    f0 = fall_cnt;
    for (i = 0; i < 200 && !rfsh_req; i++) step();
    chk(rfsh_req && !rfsh_busy, "R7", "request without grant", {rfsh_req, rfsh_busy}, 2'b10);
    repeat (3 * IVAL + 10) step();
    chk(fall_cnt == f0, "R7", "no cycle while grant low", fall_cnt, f0);

    // R8: saturated backlog serves exactly BMAX
    c0 = cbr_cnt;
    for (int k = 0; k < BMAX; k++) exp_q.push_back(K_CBR);
    rfsh_gnt = 1;
    step();
    for (i = 0; i < 200 && (rfsh_req || rfsh_busy); i++) step();
    chk(cbr_cnt - c0 == BMAX, "R8", "cycles served after stall", cbr_cnt - c0, BMAX);

    // R6: refresh spacing
    f0 = fall_cnt;
    for (i = 0; i < 300 && fall_cnt == f0; i++) step();
    t1 = fall_time;
    for (i = 0; i < 300 && fall_cnt == f0 + 1; i++) step();
    chk(fall_time - t1 == IVAL, "R6", "refresh spacing", fall_time - t1, IVAL);

    // R9: self-refresh, sleep dropped early
    for (i = 0; i < 200 && (rfsh_busy || rfsh_req); i++) step();
    exp_q.push_back(K_SELF);
    sleep_req = 1;
    for (i = 0; i < 50 && !sleep_ack; i++) step();
    chk(sleep_ack, "R9", "sleep acknowledged", int'(sleep_ack), 1);
    sleep_req = 0;
    for (i = 0; i < 200 && (sleep_ack || rfsh_busy); i++) step();
    chk(!sleep_ack && ras_n, "R9", "self-refresh left", int'(sleep_ack), 0);

    // R10: owed refresh before sleep
    for (i = 0; i < 200 && (rfsh_busy || rfsh_req); i++) step();
    rfsh_gnt = 0;
    for (i = 0; i < 200 && !rfsh_req; i++) step();
    exp_q.push_back(K_CBR);
    exp_q.push_back(K_SELF);
    sleep_req = 1;
    rfsh_gnt = 1;
    for (i = 0; i < 100 && !sleep_ack; i++) step();
    chk(sleep_ack, "R10", "sleep after owed refresh", int'(sleep_ack), 1);
    sleep_req = 0;
    for (i = 0; i < 200 && (sleep_ack || rfsh_busy); i++) step();
    rfsh_gnt = 0;
    for (i = 0; i < 100 && rfsh_busy; i++) step();
    chk(exp_q.size() == 0, "R10", "all expected cycles seen", exp_q.size(), 0);
    chk(init_done, "R11", "init_done still high", int'(init_done), 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule